// File: doc/BRIEF.md
# Page-Crossing Access Splitter

This block sits between a load/store front end and the address translation and physical memory stages. It accepts one linear-address request of one to four bytes at a time. It breaks the request into pieces that never cross a 4 KB page, has each piece translated on its own, and then issues each piece to physical memory as a byte, halfword or word access. Read data comes back piece by piece and is packed into a little-endian result. Write data is handed out from its low end, one piece at a time.

A request is accepted while the block is idle. The block ends each request with a one-cycle completion pulse that carries the read result and the outcome flags. An invalid length is refused before any translation is requested. A translation fault ends the request at once, and no memory access follows it. Translation policy, fault reporting and memory latency are the neighbours' concern. The block only follows their valid/ready-style handshakes.

Top module: `page_split_unit`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `xl_req_valid`, `mem_valid` and `done_valid` are 0.
- R2: A request whose length is 0 or greater than 4 completes with `done_error`=1. It requests no translation and issues no memory access.
- R3: The first translation of a request is for the request's own linear address. Its chunk length is the smaller of the request length and 4096 minus the address bits [11:0].
- R4: When a chunk ends on a 4 KB boundary and bytes remain, a second translation is requested at the next linear address, which is page aligned. That chunk gets a fresh page budget.
- R5: Each translation request carries the request's write and user flags. No memory access of a chunk starts before that chunk's translation response has been taken.
- R6: `mem_size` encodes the width: 0 for a byte, 1 for a halfword, 2 for a word. A chunk of 4 bytes is one word access, 2 bytes one halfword access and 1 byte one byte access, each at the translated physical address.
- R7: A 3-byte chunk is issued as a byte access at the translated physical address, followed by a halfword access at that address plus one.
- R8: For a read, the first byte returned goes to `done_rdata` bits [7:0] and each later byte to the next higher byte lane. Bits above the request length are 0. Only the low bytes of `mem_rdata` that match `mem_size` are used.
- R9: For a write, each access carries, in the low bytes of `mem_wdata`, the next unsent bytes of `req_wdata`, lowest byte first. All higher bits of `mem_wdata` are 0.
- R10: A faulting translation ends the request with `done_fault`=1 in the next cycle. No memory access follows the fault. Accesses of an earlier chunk that were already issued stay issued.
- R11: Each accepted request produces exactly one `done_valid` pulse of one cycle. While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_size` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_addr | input | 32 | Linear address of the first byte |
| req_len | input | 3 | Byte count, valid range 1 to 4 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_user | input | 1 | Access made at user privilege |
| req_wdata | input | 32 | Write data, first byte in bits [7:0] |
| xl_req_valid | output | 1 | Translation wanted for `xl_req_addr` |
| xl_req_addr | output | 32 | Linear address of the current chunk |
| xl_req_write | output | 1 | Write flag passed to translation |
| xl_req_user | output | 1 | User flag passed to translation |
| xl_rsp_valid | input | 1 | Translation response present |
| xl_rsp_paddr | input | 32 | Physical address of the chunk's first byte |
| xl_rsp_fault | input | 1 | Translation refused |
| mem_valid | output | 1 | Physical access offered |
| mem_addr | output | 32 | Physical byte address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_write | output | 1 | Access is a write |
| mem_wdata | output | 32 | Write data, low lanes used |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, low lanes used |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Assembled read data |
| done_fault | output | 1 | Request ended by a translation fault |
| done_error | output | 1 | Request refused for its length |

## Verification
Two things can fall in the same clock edge: the memory handshake that finishes the last piece of a chunk, and the switch to the next page's translation. The new translation address and the shifted write data or read shift amount must then all advance together. Requests are placed so that they straddle a boundary with 1+3, 2+2, 3+1 and 1+2 byte splits, with zero-wait and stalled neighbours. The judgement is whether the second translation address is page aligned, whether the pieces after it hold the right bytes in the right lanes, and whether each first memory access of a chunk comes after that chunk's translation response. A fault on the second page is provoked in the same way, to show that the first page's write still goes out and nothing follows the fault.

// File: rtl/psu_pkg.sv
// Shared types of the page-crossing access splitter.
package psu_pkg;
    // Sequencer state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XLATE = 2'd1,
        ST_MEM   = 2'd2,
        ST_DONE  = 2'd3
    } psu_state_e;

    // Physical access width code as seen on mem_size
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } psu_size_e;
endpackage

// File: rtl/psu_chunk_calc.sv
// Chunk length calculator.
// Gives the number of bytes the next chunk may cover: the smaller of the bytes
// still owed to the request and the bytes left before the next page boundary.
// Assumes PAGE_BITS+1 is wider than LEN_W.
module psu_chunk_calc #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int LEN_W     = 3
) (
    input  logic [ADDR_W-1:0] laddr,
    input  logic [LEN_W-1:0]  rem_len,
    output logic [LEN_W-1:0]  chunk_len
);
    localparam logic [PAGE_BITS:0] PAGE_SIZE = (PAGE_BITS + 1)'(1) << PAGE_BITS;

    logic [PAGE_BITS:0] page_left;
    logic [PAGE_BITS:0] rem_ext;

    // Compare the page budget with the bytes still to move
    always_comb begin
        page_left = PAGE_SIZE - {1'b0, laddr[PAGE_BITS-1:0]};
        rem_ext   = (PAGE_BITS + 1)'(rem_len);
        chunk_len = (page_left < rem_ext) ? page_left[LEN_W-1:0] : rem_len;
    end
endmodule

// File: rtl/psu_piece_sel.sv
// Piece selector.
// Maps the bytes left in the current chunk to the next physical access.
// 4 gives a word, 2 a halfword, and 1 or 3 a single byte. A 3-byte chunk
// therefore becomes a byte followed by a halfword.
module psu_piece_sel
    import psu_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic [LEN_W-1:0] chunk_left,
    output logic [LEN_W-1:0] piece_bytes,
    output psu_size_e        piece_size
);
    localparam logic [LEN_W-1:0] L_ONE  = LEN_W'(1);
    localparam logic [LEN_W-1:0] L_TWO  = LEN_W'(2);
    localparam logic [LEN_W-1:0] L_FOUR = LEN_W'(4);

    // Pick the access width from the remaining chunk bytes
    always_comb begin
        case (chunk_left)
            L_FOUR: begin
                piece_bytes = L_FOUR;
                piece_size  = SZ_WORD;
            end
            L_TWO: begin
                piece_bytes = L_TWO;
                piece_size  = SZ_HALF;
            end
            default: begin
                piece_bytes = L_ONE;
                piece_size  = SZ_BYTE;
            end
        endcase
    end
endmodule

// File: rtl/psu_data_path.sv
// Data path of the splitter.
// Keeps the unsent write data, which shrinks from its low end, and the read
// accumulator, which grows little-endian. Assumes step is raised only on
// a completed memory piece and that step_bytes is 1, 2 or 4.
module psu_data_path #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              step,
    input  logic [LEN_W-1:0]  step_bytes,
    input  logic [DATA_W-1:0] rd_piece,
    output logic [DATA_W-1:0] wr_piece,
    output logic [DATA_W-1:0] rd_acc
);
    localparam int SH_W = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0] wr_left;
    logic [SH_W-1:0]   shamt;
    logic [SH_W-1:0]   step_bits;
    logic [DATA_W-1:0] lane_mask;

    // Width of the current piece in bits and the matching lane mask
    always_comb begin
        step_bits = SH_W'(step_bytes) << 3;
        lane_mask = ~({DATA_W{1'b1}} << step_bits);
        wr_piece  = wr_left & lane_mask;
    end

    // Load on accept; shift write data out and read data in per piece
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_left <= '0;
            rd_acc  <= '0;
            shamt   <= '0;
        end else if (load) begin
            wr_left <= wdata_in;
            rd_acc  <= '0;
            shamt   <= '0;
        end else if (step) begin
            rd_acc  <= rd_acc + ((rd_piece & lane_mask) << shamt);
            wr_left <= wr_left >> step_bits;
            shamt   <= shamt + step_bits;
        end
    end
endmodule

// File: rtl/page_split_unit.sv
// Page-crossing access splitter, top level.
// Takes one linear request of 1..MAX_LEN bytes, splits it at page boundaries,
// translates each chunk and issues byte/halfword/word physical accesses.
// Assumes the translator answers only while xl_req_valid is high and the
// memory completes a piece in the cycle it raises mem_ready.
module page_split_unit
    import psu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int LEN_W     = 3,
    parameter int MAX_LEN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              xl_req_valid,
    output logic [ADDR_W-1:0] xl_req_addr,
    output logic              xl_req_write,
    output logic              xl_req_user,
    input  logic              xl_rsp_valid,
    input  logic [ADDR_W-1:0] xl_rsp_paddr,
    input  logic              xl_rsp_fault,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_write,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done_valid,
    output logic [DATA_W-1:0] done_rdata,
    output logic              done_fault,
    output logic              done_error
);
    localparam logic [LEN_W-1:0]   MAX_LEN_L = LEN_W'(MAX_LEN);
    localparam logic [PAGE_BITS:0] PAGE_SIZE = (PAGE_BITS + 1)'(1) << PAGE_BITS;

    psu_state_e        state;
    logic [ADDR_W-1:0] cur_la;
    logic [ADDR_W-1:0] cur_pa;
    logic [LEN_W-1:0]  rem_len;
    logic [LEN_W-1:0]  chunk_left;
    logic              is_write;
    logic              is_user;
    logic              fault_q;
    logic              error_q;

    logic [LEN_W-1:0]  chunk_len;
    logic [LEN_W-1:0]  piece_bytes;
    psu_size_e         piece_size;
    logic              accept;
    logic              len_bad;
    logic              xl_take;
    logic              piece_done;

    psu_chunk_calc #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .LEN_W     (LEN_W)
    ) u_chunk (
        .laddr     (cur_la),
        .rem_len   (rem_len),
        .chunk_len (chunk_len)
    );

    psu_piece_sel #(
        .LEN_W (LEN_W)
    ) u_piece (
        .chunk_left  (chunk_left),
        .piece_bytes (piece_bytes),
        .piece_size  (piece_size)
    );

    psu_data_path #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .wdata_in   (req_wdata),
        .step       (piece_done),
        .step_bytes (piece_bytes),
        .rd_piece   (mem_rdata),
        .wr_piece   (mem_wdata),
        .rd_acc     (done_rdata)
    );

    // Handshake decodes and port views of the sequencer state
    always_comb begin
        req_ready    = (state == ST_IDLE);
        accept       = req_valid && req_ready;
        len_bad      = (req_len == '0) || (req_len > MAX_LEN_L);
        xl_req_valid = (state == ST_XLATE);
        xl_req_addr  = cur_la;
        xl_req_write = is_write;
        xl_req_user  = is_user;
        xl_take      = xl_req_valid && xl_rsp_valid;
        mem_valid    = (state == ST_MEM);
        mem_addr     = cur_pa;
        mem_size     = piece_size;
        mem_write    = is_write;
        piece_done   = mem_valid && mem_ready;
        done_valid   = (state == ST_DONE);
        done_fault   = fault_q;
        done_error   = error_q;
    end

    // Sequencer: accept, translate a chunk, issue its pieces, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_la     <= '0;
            cur_pa     <= '0;
            rem_len    <= '0;
            chunk_left <= '0;
            is_write   <= 1'b0;
            is_user    <= 1'b0;
            fault_q    <= 1'b0;
            error_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur_la   <= req_addr;
                        rem_len  <= req_len;
                        is_write <= req_write;
                        is_user  <= req_user;
                        fault_q  <= 1'b0;
                        error_q  <= len_bad;
                        state    <= len_bad ? ST_DONE : ST_XLATE;
                    end
                end
                ST_XLATE: begin
                    if (xl_take) begin
                        if (xl_rsp_fault) begin
                            fault_q <= 1'b1;
                            state   <= ST_DONE;
                        end else begin
                            cur_pa     <= xl_rsp_paddr;
                            chunk_left <= chunk_len;
                            state      <= ST_MEM;
                        end
                    end
                end
                ST_MEM: begin
                    if (piece_done) begin
                        cur_pa     <= cur_pa + ADDR_W'(piece_bytes);
                        cur_la     <= cur_la + ADDR_W'(piece_bytes);
                        rem_len    <= rem_len - piece_bytes;
                        chunk_left <= chunk_left - piece_bytes;
                        if (chunk_left == piece_bytes) begin
                            state <= (rem_len == piece_bytes) ? ST_DONE : ST_XLATE;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R2: a refused length finishes at once with the error flag
    a_r2_bad_len_done: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && len_bad) |=> (done_valid && done_error && !xl_req_valid));

    // R3: a chunk never reaches past the end of its page
    a_r3_chunk_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (({1'b0, cur_la[PAGE_BITS-1:0]} + (PAGE_BITS + 1)'(chunk_left)) <= PAGE_SIZE));

    // R5: a chunk's first memory piece follows a taken translation response
    a_r5_mem_after_xlate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> $past(xl_take && !xl_rsp_fault));

    // R6: only the three defined width codes appear
    a_r6_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_size != 2'd3));

    // R10: a fault ends the request without any memory piece
    a_r10_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_take && xl_rsp_fault) |=> (done_valid && done_fault && !mem_valid));

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R11: a stalled piece keeps its address and width
    a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_size)));
endmodule

// File: tb/page_split_unit_test.sv
// Directed bench for page_split_unit: translator and memory models answer at
// the falling edge; each scenario task drives one request and checks it.
module page_split_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        xl_req_valid;
    logic [31:0] xl_req_addr;
    logic        xl_req_write;
    logic        xl_req_user;
    logic        xl_rsp_valid = 1'b0;
    logic [31:0] xl_rsp_paddr = '0;
    logic        xl_rsp_fault = 1'b0;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic        mem_write;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done_valid;
    logic [31:0] done_rdata;
    logic        done_fault;
    logic        done_error;

    int n_checks = 0;
    int n_fail   = 0;

    page_split_unit uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_user(req_user),
        .req_wdata(req_wdata),
        .xl_req_valid(xl_req_valid), .xl_req_addr(xl_req_addr),
        .xl_req_write(xl_req_write), .xl_req_user(xl_req_user),
        .xl_rsp_valid(xl_rsp_valid), .xl_rsp_paddr(xl_rsp_paddr),
        .xl_rsp_fault(xl_rsp_fault),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata),
        .done_valid(done_valid), .done_rdata(done_rdata),
        .done_fault(done_fault), .done_error(done_error)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Translation model: page number moved up by 0x100, offset kept
    function automatic logic [31:0] xlat(input logic [31:0] la);
        return {la[31:12] + 20'h00100, la[11:0]};
    endfunction

    // Memory content model: one byte value per physical address
    function automatic logic [7:0] bval(input logic [31:0] pa);
        return pa[7:0] ^ pa[15:8] ^ 8'h3C;
    endfunction

    // Logs of handshakes seen at the ports
    logic [31:0] ml_addr [256];
    logic [1:0]  ml_size [256];
    logic        ml_wr   [256];
    logic [31:0] ml_wd   [256];
    int          ml_cyc  [256];
    int          ml_n = 0;
    logic [31:0] xl_addr [64];
    logic        xl_wr   [64];
    logic        xl_usr  [64];
    int          xl_cyc  [64];
    int          xl_n = 0;
    int          done_n = 0;
    logic [31:0] last_rd;
    logic        last_ft;
    logic        last_er;
    int          cyc = 0;
    int          mem_wait = 0;
    int          xl_wait = 0;
    logic [19:0] fault_page = 20'hFFFFF;
    int          mcnt = 0;
    int          xcnt = 0;

    // Falling-edge models of translator and memory, and done capture
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            xl_rsp_valid = 1'b0;
            mem_ready    = 1'b0;
        end else begin
            if (xl_req_valid) begin
                if (xcnt < xl_wait) begin
                    xl_rsp_valid = 1'b0;
                    xcnt++;
                end else begin
                    xcnt = 0;
                    xl_rsp_valid = 1'b1;
                    xl_rsp_paddr = xlat(xl_req_addr);
                    xl_rsp_fault = (xl_req_addr[31:12] == fault_page);
                    xl_addr[xl_n] = xl_req_addr;
                    xl_wr[xl_n]   = xl_req_write;
                    xl_usr[xl_n]  = xl_req_user;
                    xl_cyc[xl_n]  = cyc;
                    xl_n++;
                end
            end else begin
                xl_rsp_valid = 1'b0;
                xcnt = 0;
            end
            if (mem_valid) begin
                if (mcnt < mem_wait) begin
                    mem_ready = 1'b0;
                    mcnt++;
                end else begin
                    int nb;
                    mcnt = 0;
                    mem_ready = 1'b1;
                    nb = (mem_size == 2'd2) ? 4 : (mem_size == 2'd1) ? 2 : 1;
                    for (int k = 0; k < 4; k++)
                        mem_rdata[8*k +: 8] = (k < nb) ? bval(mem_addr + 32'(k)) : 8'hEE;
                    ml_addr[ml_n] = mem_addr;
                    ml_size[ml_n] = mem_size;
                    ml_wr[ml_n]   = mem_write;
                    ml_wd[ml_n]   = mem_wdata;
                    ml_cyc[ml_n]  = cyc;
                    ml_n++;
                end
            end else begin
                mem_ready = 1'b0;
                mcnt = 0;
            end
            if (done_valid) begin
                done_n++;
                last_rd = done_rdata;
                last_ft = done_fault;
                last_er = done_error;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one request and check every port-level effect against the requirements
    task automatic do_access(input string name, input logic [31:0] la, input int len,
                             input logic wr, input logic usr, input logic [31:0] wd);
        int m0 = ml_n;
        int x0 = xl_n;
        int d0 = done_n;
        int waited = 0;
        int rem = len;
        int off = 0;
        int xi = 0;
        int pi = 0;
        logic faulted = 1'b0;
        logic bad = (len == 0) || (len > 4);
        logic [31:0] lc = la;
        logic [31:0] exp_rd = '0;
        @(negedge clk);
        req_addr = la; req_len = 3'(len); req_write = wr; req_user = usr;
        req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_n == d0 && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        repeat (3) @(negedge clk);
        chk("R11", {name, " done pulses"}, 32'(done_n - d0), 32'd1);
        chk("R2", {name, " error flag"}, 32'(last_er), 32'(bad));
        if (!bad) begin
            while (rem > 0 && !faulted) begin
                int pl = 4096 - int'(lc[11:0]);
                int c = (rem < pl) ? rem : pl;
                chk((xi == 0) ? "R3" : "R4", {name, " xlate addr"}, xl_addr[x0+xi], lc);
                chk("R5", {name, " xlate write flag"}, 32'(xl_wr[x0+xi]), 32'(wr));
                chk("R5", {name, " xlate user flag"}, 32'(xl_usr[x0+xi]), 32'(usr));
                if (lc[31:12] == fault_page) begin
                    faulted = 1'b1;
                end else begin
                    logic [31:0] pa = xlat(lc);
                    int np = (c == 3) ? 2 : 1;
                    chk("R5", {name, " memory after xlate"},
                        32'(ml_cyc[m0+pi] > xl_cyc[x0+xi]), 32'd1);
                    for (int p = 0; p < np; p++) begin
                        int nb = (c == 3) ? ((p == 0) ? 1 : 2) : c;
                        int po = (c == 3 && p == 1) ? 1 : 0;
                        logic [1:0] sz = (nb == 4) ? 2'd2 : (nb == 2) ? 2'd1 : 2'd0;
                        logic [31:0] msk = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*nb)) - 1);
                        string rq = (c == 3) ? "R7" : "R6";
                        chk(rq, {name, " piece addr"}, ml_addr[m0+pi], pa + 32'(po));
                        chk(rq, {name, " piece size"}, 32'(ml_size[m0+pi]), 32'(sz));
                        chk("R6", {name, " piece dir"}, 32'(ml_wr[m0+pi]), 32'(wr));
                        if (wr)
                            chk("R9", {name, " piece wdata"}, ml_wd[m0+pi],
                                (wd >> (8*(off+po))) & msk);
                        pi++;
                    end
                    off += c; rem -= c; lc += 32'(c);
                end
                xi++;
            end
            for (int i = 0; i < len; i++)
                exp_rd[8*i +: 8] = bval(xlat(la + 32'(i)));
            if (!wr && !faulted)
                chk("R8", {name, " read data"}, last_rd, exp_rd);
        end
        chk("R5", {name, " xlate count"}, 32'(xl_n - x0), 32'(xi));
        chk("R10", {name, " memory piece count"}, 32'(ml_n - m0), 32'(pi));
        chk("R10", {name, " fault flag"}, 32'(last_ft), 32'(faulted));
    endtask

    task automatic t_reset();
        chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);
        chk("R1", "xl_req_valid after reset", 32'(xl_req_valid), 32'd0);
        chk("R1", "mem_valid after reset", 32'(mem_valid), 32'd0);
        chk("R1", "done_valid after reset", 32'(done_valid), 32'd0);
    endtask

    task automatic t_in_page();
        do_access("word read", 32'h0000_2100, 4, 1'b0, 1'b0, '0);
        do_access("half write", 32'h0000_3202, 2, 1'b1, 1'b0, 32'hA1B2_C3D4);
        do_access("tri read", 32'h0000_4011, 3, 1'b0, 1'b1, '0);
        do_access("tri write", 32'h0000_5021, 3, 1'b1, 1'b0, 32'h99CA_FE42);
        do_access("byte user read", 32'h0000_6003, 1, 1'b0, 1'b1, '0);
    endtask

    task automatic t_straddle();
        do_access("split 2+2 read", 32'h0000_7FFE, 4, 1'b0, 1'b0, '0);
        do_access("split 3+1 read", 32'h0000_8FFD, 4, 1'b0, 1'b1, '0);
        do_access("split 1+3 write", 32'h0000_9FFF, 4, 1'b1, 1'b0, 32'h1122_3344);
        do_access("split 1+3 read", 32'h0001_0FFF, 4, 1'b0, 1'b0, '0);
    endtask

    task automatic t_stalls();
        xl_wait = 2; mem_wait = 2;
        do_access("stalled 1+2 write", 32'h0000_AFFF, 3, 1'b1, 1'b1, 32'hDEAD_BEEF);
        do_access("stalled word read", 32'h0000_B400, 4, 1'b0, 1'b0, '0);
        xl_wait = 0; mem_wait = 0;
    endtask

    task automatic t_bad_len();
        do_access("length 0", 32'h0000_C000, 0, 1'b0, 1'b0, '0);
        do_access("length 5", 32'h0000_C000, 5, 1'b1, 1'b0, 32'h5555_5555);
        do_access("length 7", 32'h0000_C000, 7, 1'b0, 1'b0, '0);
    endtask

    task automatic t_faults();
        fault_page = 20'h000D0;
        do_access("fault first page", 32'h000D_0010, 4, 1'b0, 1'b0, '0);
        fault_page = 20'h000E1;
        do_access("fault second page", 32'h000E_0FFE, 4, 1'b1, 1'b1, 32'hCAFE_F00D);
        fault_page = 20'hFFFFF;
        do_access("after fault", 32'h000E_0800, 2, 1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_in_page();
        t_straddle();
        t_stalls();
        t_bad_len();
        t_faults();
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule